// File: doc/BRIEF.md
# Column-to-Row Command Spacing Checker

This block sits beside the row-command scheduler of a banked memory controller. It remembers the last column-channel command that was issued and, for each row-channel command waiting to go out, decides how the two interact. There are three outcomes. The row command may need a minimum number of clock cycles after the column command. The pairing may be illegal, in which case it must never issue. Or the pairing may be allowed but hazardous, which gives a warning and does not block. Each pairing is sorted into one of nine numbered cases, and the case number is brought out on a port.

Column commands are captured on a plain strobe, because they have already been issued. The row side follows valid/ready rules. `row_ready` does not depend on `row_valid`. A row command transfers in a cycle where both are high. Holding `row_valid` high while `row_ready` is low is back-pressure: the scheduler keeps the command and its fields steady until ready rises. An illegal pairing holds `row_ready` low until a new column command changes the pairing. Two timing registers set the read-to-precharge and retire-to-precharge spacings. A small write port sets them.

Top module: `c2r_spacing_chk`

## Requirements
- R1: After reset the held column command is a no-op, so any row command gives case 1 with `row_ready` high. The read-to-precharge register resets to 4 and the retire-to-precharge register resets to 7.
- R2: Pairings without interaction have spacing 0 and no error or warning flag. They are checked in this priority order: column no-op gives case 1, row no-op gives case 9, differing device gives case 2, and a row bank that is not near the column bank gives case 3.
- R3: Column codes are 0 no-op, 1 read, 2 write, 3 retire (a command that lets the write buffer retire), 4 column precharge (treated as no-op), 5 write with auto-precharge (treated as write), 6 read with auto-precharge (treated as read) and 7 reserved (no-op). Row codes are 0 no-op, 1 activate, 2 precharge, 3 refresh-activate (treated as activate) and 4 refresh-precharge (treated as precharge). Row codes 5 to 7 are no-op.
- R4: With `adj_mode`=1 a bank is near when it is the same bank or one above or one below. Bank 0 has no lower neighbour and the top bank has no upper neighbour, so the range does not wrap. With `adj_mode`=0 only the same bank is near.
- R5: A near activate is illegal. At the same bank it is case 4. At a neighbour bank it is case 5. Spacing is 0 and `row_ready` is low.
- R6: A read column command followed by a near precharge is case 6 and needs the read-to-precharge spacing.
- R7: A retire column command followed by a near precharge is case 7 and needs the retire-to-precharge spacing. The bank compared for a retire is the one held in the write buffer, not the retire's own bank field.
- R8: A write column command followed by a near precharge is case 8. It raises the hazard flag with spacing 0 and leaves `row_ready` high.
- R9: Cycle k=0 is the first cycle after the clock edge that captures a column command. In cycle k, `row_ready` is high when the pairing is legal and k is at least the spacing. A new column command restarts the count.
- R10: `cmd_illegal` and `cmd_hazard` are high only while `row_valid` is high. `row_ready`, `case_num` and `spacing` do not depend on `row_valid`.
- R11: A write with `cfg_we`=1 loads `cfg_wdata` into the read-to-precharge register when `cfg_addr`=0, and into the retire-to-precharge register when `cfg_addr`=1. The new value applies from the next cycle.
- R12: A write or write-with-auto-precharge column command loads its bank into the write buffer. A later retire compares against that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_issue | input | 1 | Capture strobe for an issued column command |
| col_op | input | 3 | Column opcode |
| col_dev | input | DEV_W | Column target device |
| col_bank | input | BANK_W | Column target bank |
| row_valid | input | 1 | Row command is waiting |
| row_op | input | 3 | Row opcode |
| row_dev | input | DEV_W | Row target device |
| row_bank | input | BANK_W | Row target bank |
| adj_mode | input | 1 | 1: neighbouring banks interact |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_addr | input | 1 | 0 read-to-precharge, 1 retire-to-precharge |
| cfg_wdata | input | TW | Timing register write value |
| row_ready | output | 1 | Row command may issue now |
| case_num | output | 4 | Interaction case, 1 to 9 |
| spacing | output | TW | Required spacing in cycles |
| cmd_illegal | output | 1 | Waiting row command is illegal |
| cmd_hazard | output | 1 | Waiting row command is hazardous |

## Verification
The bench goes after the bank-range edges and after the aliased opcodes. A design that wrapped adjacency would call bank 0 against bank 15 near. A design that forgot an alias would report a refresh or auto-precharge pairing as case 1 or 9. It also issues a retire whose own bank field differs from the write-buffer bank, in both directions. A checker that used the field would move that pairing between cases 3 and 7. Ready is sampled in every cycle up to and one past the spacing, after default and reprogrammed timing values and after a restarting column command. This catches off-by-one counting, a stale register value, and a hazard or illegal case that blocks or releases the wrong way.

// File: rtl/c2r_pkg.sv
package c2r_pkg;

  typedef enum logic [1:0] {
    CK_NONE   = 2'd0,
    CK_RD     = 2'd1,
    CK_WR     = 2'd2,
    CK_RETIRE = 2'd3
  } col_kind_e;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_ACT  = 2'd1,
    RK_PRE  = 2'd2
  } row_kind_e;

  localparam logic [3:0] CASE_COL_NOP = 4'd1;
  localparam logic [3:0] CASE_OTH_DEV = 4'd2;
  localparam logic [3:0] CASE_FAR     = 4'd3;
  localparam logic [3:0] CASE_ACT_SAME = 4'd4;
  localparam logic [3:0] CASE_ACT_NEAR = 4'd5;
  localparam logic [3:0] CASE_RD_PRE  = 4'd6;
  localparam logic [3:0] CASE_RT_PRE  = 4'd7;
  localparam logic [3:0] CASE_WR_PRE  = 4'd8;
  localparam logic [3:0] CASE_ROW_NOP = 4'd9;

  // Column opcode folding: auto-precharge variants behave as their base op.
  function automatic col_kind_e col_kind(input logic [2:0] op);
    case (op)
      3'd1, 3'd6: col_kind = CK_RD;
      3'd2, 3'd5: col_kind = CK_WR;
      3'd3:       col_kind = CK_RETIRE;
      default:    col_kind = CK_NONE;
    endcase
  endfunction

  // Row opcode folding: refresh forms behave as activate/precharge.
  function automatic row_kind_e row_kind(input logic [2:0] op);
    case (op)
      3'd1, 3'd3: row_kind = RK_ACT;
      3'd2, 3'd4: row_kind = RK_PRE;
      default:    row_kind = RK_NONE;
    endcase
  endfunction

endpackage

// File: rtl/c2r_timing_regs.sv
module c2r_timing_regs
  import c2r_pkg::*;
#(
  parameter int TW     = 6,
  parameter int RD_RST = 4,
  parameter int RT_RST = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_addr,
  input  logic [TW-1:0] cfg_wdata,
  output logic [TW-1:0] rd2pre,
  output logic [TW-1:0] rt2pre
);

  localparam logic [TW-1:0] RD_INIT = TW'(RD_RST);
  localparam logic [TW-1:0] RT_INIT = TW'(RT_RST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd2pre <= RD_INIT;
      rt2pre <= RT_INIT;
    end else if (cfg_we) begin
      if (cfg_addr) rt2pre <= cfg_wdata;
      else          rd2pre <= cfg_wdata;
    end
  end

  assert_cfg_rd_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_addr) |=> (rd2pre == $past(cfg_wdata)));

  assert_cfg_rt_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr) |=> (rt2pre == $past(cfg_wdata)));

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(rd2pre) && $stable(rt2pre)));

endmodule

// File: rtl/c2r_col_track.sv
module c2r_col_track
  import c2r_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int BANK_W = 4,
  parameter int TW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              col_issue,
  input  logic [2:0]        col_op,
  input  logic [DEV_W-1:0]  col_dev,
  input  logic [BANK_W-1:0] col_bank,
  output col_kind_e         held_kind,
  output logic [DEV_W-1:0]  held_dev,
  output logic [BANK_W-1:0] held_bank,
  output logic [TW-1:0]     elapsed
);

  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  col_kind_e         in_kind;
  logic [BANK_W-1:0] wbuf_bank;

  assign in_kind = col_kind(col_op);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_kind <= CK_NONE;
      held_dev  <= '0;
      held_bank <= '0;
      wbuf_bank <= '0;
    end else if (col_issue) begin
      held_kind <= in_kind;
      held_dev  <= col_dev;
      // A retire acts on whatever bank the write buffer holds.
      held_bank <= (in_kind == CK_RETIRE) ? wbuf_bank : col_bank;
      if (in_kind == CK_WR) wbuf_bank <= col_bank;
    end
  end

  // Saturating cycles-since-column counter; starts saturated so ready is free.
  always_ff @(posedge clk) begin
    if (!rst_n)                elapsed <= CNT_MAX;
    else if (col_issue)        elapsed <= '0;
    else if (elapsed != CNT_MAX) elapsed <= elapsed + 1'b1;
  end

  assert_elapsed_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    col_issue |=> (elapsed == '0));

  assert_elapsed_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_issue && elapsed != CNT_MAX) |=> (elapsed == $past(elapsed) + 1'b1));

  assert_wbuf_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (col_issue && (col_op == 3'd2 || col_op == 3'd5)) |=> (wbuf_bank == $past(col_bank)));

endmodule

// File: rtl/c2r_classify.sv
module c2r_classify
  import c2r_pkg::*;
#(
  parameter int DEV_W     = 5,
  parameter int NUM_BANKS = 16,
  parameter int BANK_W    = 4,
  parameter int TW        = 6
) (
  input  col_kind_e         ckind,
  input  logic [DEV_W-1:0]  cdev,
  input  logic [BANK_W-1:0] cbank,
  input  logic [2:0]        row_op,
  input  logic [DEV_W-1:0]  rdev,
  input  logic [BANK_W-1:0] rbank,
  input  logic              adj_mode,
  input  logic [TW-1:0]     rd2pre,
  input  logic [TW-1:0]     rt2pre,
  output logic [3:0]        case_num,
  output logic [TW-1:0]     spacing,
  output logic              illegal,
  output logic              hazard
);

  row_kind_e            rkind;
  logic                 same_bank;
  logic                 near;
  logic [NUM_BANKS-1:0] near_vec;

  assign rkind     = row_kind(row_op);
  assign same_bank = (cbank == rbank);

  // One slot per bank: slot g fires when the column bank is g and the row
  // bank is g or, in dependent mode, a neighbour that exists in range.
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_near
    localparam logic [BANK_W-1:0] BG = BANK_W'(g);
    logic lo_hit, hi_hit;
    if (g > 0) begin : g_lo
      assign lo_hit = adj_mode && (rbank == BANK_W'(g - 1));
    end else begin : g_nolo
      assign lo_hit = 1'b0;
    end
    if (g < NUM_BANKS - 1) begin : g_hi
      assign hi_hit = adj_mode && (rbank == BANK_W'(g + 1));
    end else begin : g_nohi
      assign hi_hit = 1'b0;
    end
    assign near_vec[g] = (cbank == BG) && ((rbank == BG) || lo_hit || hi_hit);
  end

  assign near = |near_vec;

  always_comb begin
    case_num = CASE_COL_NOP;
    spacing  = '0;
    illegal  = 1'b0;
    hazard   = 1'b0;
    if (ckind == CK_NONE) begin
      case_num = CASE_COL_NOP;
    end else if (rkind == RK_NONE) begin
      case_num = CASE_ROW_NOP;
    end else if (cdev != rdev) begin
      case_num = CASE_OTH_DEV;
    end else if (!near) begin
      case_num = CASE_FAR;
    end else if (rkind == RK_ACT) begin
      case_num = same_bank ? CASE_ACT_SAME : CASE_ACT_NEAR;
      illegal  = 1'b1;
    end else begin
      case (ckind)
        CK_RD: begin
          case_num = CASE_RD_PRE;
          spacing  = rd2pre;
        end
        CK_RETIRE: begin
          case_num = CASE_RT_PRE;
          spacing  = rt2pre;
        end
        default: begin
          case_num = CASE_WR_PRE;
          hazard   = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/c2r_spacing_chk.sv
module c2r_spacing_chk
  import c2r_pkg::*;
#(
  parameter int DEV_W     = 5,
  parameter int NUM_BANKS = 16,
  parameter int TW        = 6,
  parameter int RD_RST    = 4,
  parameter int RT_RST    = 7,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              col_issue,
  input  logic [2:0]        col_op,
  input  logic [DEV_W-1:0]  col_dev,
  input  logic [BANK_W-1:0] col_bank,
  input  logic              row_valid,
  input  logic [2:0]        row_op,
  input  logic [DEV_W-1:0]  row_dev,
  input  logic [BANK_W-1:0] row_bank,
  input  logic              adj_mode,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [TW-1:0]     cfg_wdata,
  output logic              row_ready,
  output logic [3:0]        case_num,
  output logic [TW-1:0]     spacing,
  output logic              cmd_illegal,
  output logic              cmd_hazard
);

  logic [TW-1:0]     rd2pre, rt2pre, elapsed;
  col_kind_e         held_kind;
  logic [DEV_W-1:0]  held_dev;
  logic [BANK_W-1:0] held_bank;
  logic              cls_illegal, cls_hazard;

  c2r_timing_regs #(.TW(TW), .RD_RST(RD_RST), .RT_RST(RT_RST)) tregs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd2pre(rd2pre), .rt2pre(rt2pre)
  );

  c2r_col_track #(.DEV_W(DEV_W), .BANK_W(BANK_W), .TW(TW)) track_i (
    .clk(clk), .rst_n(rst_n), .col_issue(col_issue), .col_op(col_op),
    .col_dev(col_dev), .col_bank(col_bank), .held_kind(held_kind),
    .held_dev(held_dev), .held_bank(held_bank), .elapsed(elapsed)
  );

  c2r_classify #(.DEV_W(DEV_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .TW(TW)) cls_i (
    .ckind(held_kind), .cdev(held_dev), .cbank(held_bank), .row_op(row_op),
    .rdev(row_dev), .rbank(row_bank), .adj_mode(adj_mode), .rd2pre(rd2pre),
    .rt2pre(rt2pre), .case_num(case_num), .spacing(spacing),
    .illegal(cls_illegal), .hazard(cls_hazard)
  );

  assign row_ready   = !cls_illegal && (elapsed >= spacing);
  assign cmd_illegal = row_valid && cls_illegal;
  assign cmd_hazard  = row_valid && cls_hazard;

  assert_illegal_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cls_illegal |-> !row_ready);

  assert_hazard_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cls_hazard |-> (row_ready && spacing == '0));

  assert_verdict_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cls_illegal, cls_hazard}));

  assert_quiet_cases_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (case_num == 4'd1 || case_num == 4'd2 || case_num == 4'd3 || case_num == 4'd9)
      |-> (!cls_illegal && !cls_hazard && spacing == '0 && row_ready));

  assert_case_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (case_num >= 4'd1 && case_num <= 4'd9));

endmodule

// File: tb/c2r_spacing_chk_tb_top.sv
module c2r_spacing_chk_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       col_issue = 1'b0;
  logic [2:0] col_op = '0;
  logic [4:0] col_dev = 5'd3;
  logic [3:0] col_bank = '0;
  logic       row_valid = 1'b0;
  logic [2:0] row_op = '0;
  logic [4:0] row_dev = '0;
  logic [3:0] row_bank = '0;
  logic       adj_mode = 1'b1;
  logic       cfg_we = 1'b0;
  logic       cfg_addr = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic       row_ready, cmd_illegal, cmd_hazard;
  logic [3:0] case_num;
  logic [5:0] spacing;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  c2r_spacing_chk dut_i (
    .clk(clk), .rst_n(rst_n), .col_issue(col_issue), .col_op(col_op),
    .col_dev(col_dev), .col_bank(col_bank), .row_valid(row_valid),
    .row_op(row_op), .row_dev(row_dev), .row_bank(row_bank),
    .adj_mode(adj_mode), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .row_ready(row_ready), .case_num(case_num),
    .spacing(spacing), .cmd_illegal(cmd_illegal), .cmd_hazard(cmd_hazard)
  );

  typedef struct packed {
    logic [2:0] cop;   logic [3:0] cbank; logic [3:0] wbank;
    logic [2:0] rop;   logic [4:0] rdev;  logic [3:0] rbank; logic adj;
    logic [3:0] ecase; logic [5:0] esp;   logic eill; logic ehaz;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 4'd5,  4'd5,  3'd1, 5'd3, 4'd5,  1'b1, 4'd1, 6'd0, 1'b0, 1'b0}, // R2 col nop
    '{3'd1, 4'd5,  4'd5,  3'd0, 5'd3, 4'd5,  1'b1, 4'd9, 6'd0, 1'b0, 1'b0}, // R2 row nop
    '{3'd1, 4'd5,  4'd5,  3'd2, 5'd4, 4'd5,  1'b1, 4'd2, 6'd0, 1'b0, 1'b0}, // R2 other dev
    '{3'd1, 4'd5,  4'd5,  3'd2, 5'd3, 4'd9,  1'b1, 4'd3, 6'd0, 1'b0, 1'b0}, // R2 far bank
    '{3'd2, 4'd5,  4'd5,  3'd1, 5'd3, 4'd5,  1'b1, 4'd4, 6'd0, 1'b1, 1'b0}, // R5 same act
    '{3'd1, 4'd5,  4'd5,  3'd1, 5'd3, 4'd6,  1'b1, 4'd5, 6'd0, 1'b1, 1'b0}, // R5 near act
    '{3'd1, 4'd5,  4'd5,  3'd2, 5'd3, 4'd4,  1'b1, 4'd6, 6'd4, 1'b0, 1'b0}, // R6
    '{3'd3, 4'd12, 4'd5,  3'd2, 5'd3, 4'd5,  1'b1, 4'd7, 6'd7, 1'b0, 1'b0}, // R7 wbuf bank
    '{3'd2, 4'd5,  4'd5,  3'd2, 5'd3, 4'd6,  1'b1, 4'd8, 6'd0, 1'b0, 1'b1}, // R8
    '{3'd6, 4'd5,  4'd5,  3'd4, 5'd3, 4'd5,  1'b1, 4'd6, 6'd4, 1'b0, 1'b0}, // R3 rda/refp
    '{3'd5, 4'd5,  4'd5,  3'd3, 5'd3, 4'd4,  1'b1, 4'd5, 6'd0, 1'b1, 1'b0}, // R3 wra/refa
    '{3'd4, 4'd5,  4'd5,  3'd2, 5'd3, 4'd5,  1'b1, 4'd1, 6'd0, 1'b0, 1'b0}, // R3 col prec
    '{3'd1, 4'd0,  4'd0,  3'd2, 5'd3, 4'd15, 1'b1, 4'd3, 6'd0, 1'b0, 1'b0}, // R4 no wrap low
    '{3'd1, 4'd15, 4'd15, 3'd1, 5'd3, 4'd0,  1'b1, 4'd3, 6'd0, 1'b0, 1'b0}, // R4 no wrap high
    '{3'd1, 4'd5,  4'd5,  3'd1, 5'd3, 4'd6,  1'b0, 4'd3, 6'd0, 1'b0, 1'b0}, // R4 indep mode
    '{3'd1, 4'd5,  4'd5,  3'd2, 5'd3, 4'd5,  1'b0, 4'd6, 6'd4, 1'b0, 1'b0}, // R4 indep same
    '{3'd7, 4'd5,  4'd5,  3'd1, 5'd3, 4'd5,  1'b1, 4'd1, 6'd0, 1'b0, 1'b0}, // R3 reserved col
    '{3'd3, 4'd5,  4'd9,  3'd2, 5'd3, 4'd5,  1'b1, 4'd3, 6'd0, 1'b0, 1'b0}, // R12 wbuf far
    '{3'd1, 4'd5,  4'd5,  3'd5, 5'd3, 4'd5,  1'b1, 4'd9, 6'd0, 1'b0, 1'b0}  // R3 row rsvd
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue_col(input logic [2:0] op, input logic [3:0] bank);
    @(negedge clk);
    col_issue = 1'b1; col_op = op; col_bank = bank; col_dev = 5'd3;
    @(negedge clk);
    col_issue = 1'b0;
  endtask

  // Check ready over cycles k=0..sp+1 after the capture edge (R9).
  task automatic ready_walk(input int sp, input bit ill, input string req);
    #1 chk({req, " R9 ready k=0"}, int'(row_ready), int'(!ill && sp == 0));
    for (int k = 1; k <= sp + 1; k++) begin
      @(negedge clk); #1;
      chk({req, " R9 ready"}, int'(row_ready), int'(!ill && k >= sp));
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    string tag;
    tag = $sformatf("vec%0d", idx);
    issue_col(3'd2, v.wbank);
    @(negedge clk);
    col_issue = 1'b1; col_op = v.cop; col_bank = v.cbank; col_dev = 5'd3;
    row_valid = 1'b0;
    @(negedge clk);
    col_issue = 1'b0; row_valid = 1'b1; row_op = v.rop; row_dev = v.rdev;
    row_bank = v.rbank; adj_mode = v.adj;
    #1;
    chk({tag, " R2 case"}, int'(case_num), int'(v.ecase));
    chk({tag, " R6 spacing"}, int'(spacing), int'(v.esp));
    chk({tag, " R5 illegal"}, int'(cmd_illegal), int'(v.eill));
    chk({tag, " R8 hazard"}, int'(cmd_hazard), int'(v.ehaz));
    ready_walk(int'(v.esp), v.eill, tag);
    row_valid = 1'b0; adj_mode = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, column held as no-op.
    row_valid = 1'b1; row_op = 3'd1; row_dev = 5'd3; row_bank = 4'd0;
    #1;
    chk("R1 reset case", int'(case_num), 1);
    chk("R1 reset ready", int'(row_ready), 1);
    chk("R1 reset illegal", int'(cmd_illegal), 0);
    row_valid = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R10: illegal pairing without row_valid raises no flag but blocks ready.
    issue_col(3'd1, 4'd7);
    row_valid = 1'b0; row_op = 3'd1; row_dev = 5'd3; row_bank = 4'd7;
    #1;
    chk("R10 flag masked", int'(cmd_illegal), 0);
    chk("R10 case visible", int'(case_num), 4);
    chk("R10 ready blocked", int'(row_ready), 0);
    row_valid = 1'b1; #1;
    chk("R10 flag with valid", int'(cmd_illegal), 1);
    row_valid = 1'b0;

    // R11: reprogram both spacings, then observe them in use.
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = 6'd2;
    @(negedge clk); cfg_addr = 1'b1; cfg_wdata = 6'd3;
    @(negedge clk); cfg_we = 1'b0;
    issue_col(3'd1, 4'd8);
    row_valid = 1'b1; row_op = 3'd2; row_dev = 5'd3; row_bank = 4'd9;
    #1 chk("R11 rd2pre spacing", int'(spacing), 2);
    ready_walk(2, 1'b0, "R11 rd");
    // R9: a new column command restarts the count.
    @(negedge clk); col_issue = 1'b1; col_op = 3'd1; col_bank = 4'd8;
    @(negedge clk); col_issue = 1'b0;
    #1 chk("R9 restart ready low", int'(row_ready), 0);
    issue_col(3'd2, 4'd10);
    issue_col(3'd3, 4'd1);
    row_bank = 4'd11;
    #1 chk("R11 rt2pre spacing", int'(spacing), 3);
    chk("R7 retire case via wbuf R12", int'(case_num), 7);
    ready_walk(3, 1'b0, "R11 rt");
    row_valid = 1'b0;

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule